// File: doc/BRIEF.md
# Shadow and SMRAM Memory Decoder

This block sits in the memory path of a 486-class system controller and steers each processor memory cycle either to on-board DRAM or to the external bus. It looks at the physical address, the kind of access (data read, data write or code fetch), whether the processor is in system management mode, and four configuration bytes held elsewhere in the controller: a segment-enable byte for the option-ROM area, a control byte for the BIOS area and the global shadow read and write enables, an SMM control byte, and an SMI status byte.

The decision covers three areas. The first is the option-ROM area at 0xC0000–0xDFFFF, shadowed in 16KB pieces. The second is the BIOS area at 0xE0000–0xFFFFF, shadowed in 32KB pieces. The third is a set of SMRAM windows. One of those windows moves its DRAM backing store to a different base according to a field of the status byte, so the block also produces the DRAM address to use. Two summary flags report whether BIOS shadowing is active for reads and for writes. All outputs are registered, so the result for an access appears one clock after its inputs are presented.

Top module: `shsm_decoder`

## Requirements
- R1: While `rst_n` is low, and after reset until the first decoded cycle, `route_dram`, `smram_hit`, `bios_shadow_rd` and `bios_shadow_wr` are 0 and `dram_addr` is all zeros.
- R2: Outputs are registered. Inputs present at a rising clock edge determine the outputs from just after that edge until the next edge. A change of input between edges does not change the outputs.
- R3: An address below 0xA0000, or at or above 0x100000, is routed to DRAM (`route_dram`=1) with `dram_addr` equal to the address.
- R4: The range 0xC0000–0xDFFFF is made of eight 16KB segments. Segment i starts at 0xC0000 + i·0x4000 and is enabled by bit i of `shadow_seg_cfg`.
- R5: The range 0xE0000–0xFFFFF is made of four 32KB segments. Segment i starts at 0xE0000 + i·0x8000 and is enabled by bit i of `shadow_ctl_cfg` (bits 3:0).
- R6: In an enabled shadow segment, a read or code fetch (`acc_kind` 0 or 2) goes to DRAM when `shadow_ctl_cfg` bit 4 is 1, and a write (`acc_kind` 1) goes to DRAM when bit 5 is 1. Otherwise the access goes to the external bus.
- R7: A disabled shadow segment sends every access to the external bus. So does 0xA0000–0xBFFFF when no active SMRAM window covers it. In both cases `dram_addr` equals the address.
- R8: `smm_ctl_cfg` bits 5:4 select the SMRAM mode. Value 00 means no window. Value 01 means a 128KB window at 0xA0000–0xBFFFF mapped to the same DRAM addresses.
- R9: Mode 10 is a 64KB window at 0xE0000–0xEFFFF mapped to itself. It is active only when `shadow_ctl_cfg` bits 1:0 are both 0; otherwise shadow decoding applies.
- R10: Mode 11 is a 32KB window at 0xA8000–0xAFFFF. Its DRAM address is 0x68000 plus the offset when `smi_stat_cfg` bits 7:6 equal 10, and 0x38000 plus the offset otherwise.
- R11: `smram_hit` is 1 when an access falls inside the active window. Such an access goes to DRAM, with the window's DRAM address, when `in_smm` is 1 or `smm_ctl_cfg` bit 3 is 1. Otherwise it goes to the external bus with `dram_addr` equal to the address.
- R12: In mode 01 with `smm_ctl_cfg` bit 0 set, a code fetch in 0xA0000–0xBFFFF goes to DRAM even outside SMM with bit 3 clear.
- R13: `bios_shadow_rd` is 1 when any of `shadow_ctl_cfg` bits 3:0 is set together with bit 4. `bios_shadow_wr` is 1 when any of bits 3:0 is set together with bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Physical address of the cycle |
| acc_kind | input | 2 | 0 read, 1 write, 2 code fetch |
| in_smm | input | 1 | Processor is in system management mode |
| shadow_seg_cfg | input | 8 | Enables for the 16KB option-ROM segments |
| shadow_ctl_cfg | input | 8 | BIOS segment enables [3:0], shadow read [4], shadow write [5] |
| smm_ctl_cfg | input | 8 | Code-to-DRAM [0], open outside SMM [3], mode [5:4] |
| smi_stat_cfg | input | 8 | Relocation select for mode 11 in [7:6] |
| route_dram | output | 1 | 1: cycle goes to DRAM; 0: external bus |
| dram_addr | output | ADDR_W | Address presented to DRAM |
| smram_hit | output | 1 | Access falls inside the active SMRAM window |
| bios_shadow_rd | output | 1 | BIOS-area read shadowing active |
| bios_shadow_wr | output | 1 | BIOS-area write shadowing active |

## Verification
The bench builds the decoder with the default 24-bit address. This makes addresses above the first megabyte reachable, so the wrap-free treatment of extended memory is exercised beside the legacy hole. The table walks every SMRAM mode, both relocation bases of the 32KB window, and the BIOS window being suppressed by a low BIOS segment. It also covers per-segment enables at both granularities and the code-fetch exception. Directed steps check the reset values and the one-cycle register latency.

// File: rtl/shsm_pkg.sv
package shsm_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SMM_OFF    = 2'b00,
        SMM_LOWWIN = 2'b01,
        SMM_BIOSWN = 2'b10,
        SMM_RELOC  = 2'b11
    } smm_mode_e;

    localparam int CFG_W      = 8;
    localparam int LO_SEGS    = 8;   // 16KB segments in C/D area
    localparam int HI_SEGS    = 4;   // 32KB segments in E/F area
    localparam int LO_SEG_LSB = 14;
    localparam int HI_SEG_LSB = 15;
    localparam int MB_BITS    = 20;

    // bit positions inside the configuration bytes
    localparam int SH_RD_BIT    = 4;
    localparam int SH_WR_BIT    = 5;
    localparam int SMM_CODE_BIT = 0;
    localparam int SMM_OPEN_BIT = 3;

    // relocation bases for the 32KB window, in 32KB units
    localparam logic [4:0] RELOC_BASE_HI = 5'h0D;  // 0x68000
    localparam logic [4:0] RELOC_BASE_LO = 5'h07;  // 0x38000

endpackage

// File: rtl/shsm_shadow_map.sv
module shsm_shadow_map
    import shsm_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        acc_kind,
    input  logic [CFG_W-1:0]  seg_cfg,
    input  logic [CFG_W-1:0]  ctl_cfg,
    output logic              in_opt_area,
    output logic              in_bios_area,
    output logic              shadow_dram,
    output logic              bios_rd_flag,
    output logic              bios_wr_flag
);
    localparam int LO_IDX_W = $clog2(LO_SEGS);
    localparam int HI_IDX_W = $clog2(HI_SEGS);

    logic              below_mb;
    logic [LO_SEGS-1:0] lo_sel;
    logic [HI_SEGS-1:0] hi_sel;
    logic              seg_on;
    logic              is_write;

    assign below_mb     = (addr >> MB_BITS) == '0;
    assign in_opt_area  = below_mb && (addr[MB_BITS-1:17] == 3'b110);
    assign in_bios_area = below_mb && (addr[MB_BITS-1:17] == 3'b111);

    generate
        for (genvar i = 0; i < LO_SEGS; i++) begin : g_lo
            assign lo_sel[i] = in_opt_area && seg_cfg[i] &&
                (addr[LO_SEG_LSB +: LO_IDX_W] == LO_IDX_W'(i));
        end
        for (genvar j = 0; j < HI_SEGS; j++) begin : g_hi
            assign hi_sel[j] = in_bios_area && ctl_cfg[j] &&
                (addr[HI_SEG_LSB +: HI_IDX_W] == HI_IDX_W'(j));
        end
    endgenerate

    assign seg_on   = (|lo_sel) || (|hi_sel);
    assign is_write = (acc_kind == ACC_WRITE);

    always_comb begin
        shadow_dram = 1'b0;
        if (seg_on)
            shadow_dram = is_write ? ctl_cfg[SH_WR_BIT] : ctl_cfg[SH_RD_BIT];
    end

    assign bios_rd_flag = (|ctl_cfg[HI_SEGS-1:0]) && ctl_cfg[SH_RD_BIT];
    assign bios_wr_flag = (|ctl_cfg[HI_SEGS-1:0]) && ctl_cfg[SH_WR_BIT];

endmodule

// File: rtl/shsm_smram_win.sv
module shsm_smram_win
    import shsm_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        acc_kind,
    input  logic              in_smm,
    input  logic [CFG_W-1:0]  ctl_cfg,
    input  logic [CFG_W-1:0]  smm_cfg,
    input  logic [CFG_W-1:0]  stat_cfg,
    output logic              win_hit,
    output logic              win_dram,
    output logic [ADDR_W-1:0] win_addr
);
    smm_mode_e   mode;
    logic        below_mb;
    logic        granted;
    logic [4:0]  reloc_base;

    assign mode       = smm_mode_e'(smm_cfg[5:4]);
    assign below_mb   = (addr >> MB_BITS) == '0;
    assign granted    = in_smm || smm_cfg[SMM_OPEN_BIT];
    assign reloc_base = (stat_cfg[7:6] == 2'b10) ? RELOC_BASE_HI : RELOC_BASE_LO;

    always_comb begin
        win_hit  = 1'b0;
        win_dram = 1'b0;
        win_addr = addr;
        unique case (mode)
            SMM_OFF: ;
            SMM_LOWWIN: begin
                win_hit  = below_mb && (addr[MB_BITS-1:17] == 3'b101);
                win_dram = win_hit && (granted ||
                           (smm_cfg[SMM_CODE_BIT] && acc_kind == ACC_FETCH));
            end
            SMM_BIOSWN: begin
                win_hit  = below_mb && (addr[MB_BITS-1:16] == 4'hE) &&
                           (ctl_cfg[1:0] == 2'b00);
                win_dram = win_hit && granted;
            end
            SMM_RELOC: begin
                win_hit  = below_mb && (addr[MB_BITS-1:15] == 5'b10101);
                win_dram = win_hit && granted;
                if (win_dram)
                    win_addr = ADDR_W'({reloc_base, addr[14:0]});
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/shsm_decoder.sv
module shsm_decoder
    import shsm_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        acc_kind,
    input  logic              in_smm,
    input  logic [7:0]        shadow_seg_cfg,
    input  logic [7:0]        shadow_ctl_cfg,
    input  logic [7:0]        smm_ctl_cfg,
    input  logic [7:0]        smi_stat_cfg,
    output logic              route_dram,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              smram_hit,
    output logic              bios_shadow_rd,
    output logic              bios_shadow_wr
);
    logic              opt_area, bios_area, sh_dram, brd, bwr;
    logic              w_hit, w_dram;
    logic [ADDR_W-1:0] w_addr;
    logic              legacy_hole;
    logic              nxt_dram;
    logic [ADDR_W-1:0] nxt_addr;

    shsm_shadow_map #(.ADDR_W(ADDR_W)) shadow_i (
        .addr         (addr),
        .acc_kind     (acc_kind),
        .seg_cfg      (shadow_seg_cfg),
        .ctl_cfg      (shadow_ctl_cfg),
        .in_opt_area  (opt_area),
        .in_bios_area (bios_area),
        .shadow_dram  (sh_dram),
        .bios_rd_flag (brd),
        .bios_wr_flag (bwr)
    );

    shsm_smram_win #(.ADDR_W(ADDR_W)) smram_i (
        .addr     (addr),
        .acc_kind (acc_kind),
        .in_smm   (in_smm),
        .ctl_cfg  (shadow_ctl_cfg),
        .smm_cfg  (smm_ctl_cfg),
        .stat_cfg (smi_stat_cfg),
        .win_hit  (w_hit),
        .win_dram (w_dram),
        .win_addr (w_addr)
    );

    assign legacy_hole = ((addr >> MB_BITS) == '0) && (addr[MB_BITS-1:17] >= 3'b101);

    always_comb begin
        nxt_addr = addr;
        if (w_hit) begin
            nxt_dram = w_dram;
            nxt_addr = w_addr;
        end else if (opt_area || bios_area) begin
            nxt_dram = sh_dram;
        end else begin
            nxt_dram = !legacy_hole;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_dram     <= 1'b0;
            dram_addr      <= '0;
            smram_hit      <= 1'b0;
            bios_shadow_rd <= 1'b0;
            bios_shadow_wr <= 1'b0;
        end else begin
            route_dram     <= nxt_dram;
            dram_addr      <= nxt_addr;
            smram_hit      <= w_hit;
            bios_shadow_rd <= brd;
            bios_shadow_wr <= bwr;
        end
    end

endmodule

// File: rtl/shsm_decoder_chk.sv
module shsm_decoder_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        acc_kind,
    input logic              in_smm,
    input logic [7:0]        shadow_seg_cfg,
    input logic [7:0]        shadow_ctl_cfg,
    input logic [7:0]        smm_ctl_cfg,
    input logic [7:0]        smi_stat_cfg,
    input logic              route_dram,
    input logic [ADDR_W-1:0] dram_addr,
    input logic              smram_hit,
    input logic              bios_shadow_rd,
    input logic              bios_shadow_wr
);
    logic conv_addr, opt_area, reloc_win;
    assign conv_addr = (addr < ADDR_W'('hA0000)) || (addr >= ADDR_W'('h100000));
    assign opt_area  = (addr >= ADDR_W'('hC0000)) && (addr < ADDR_W'('hE0000));
    assign reloc_win = (addr >= ADDR_W'('hA8000)) && (addr < ADDR_W'('hB0000));

    assert_conv_dram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_addr |=> route_dram && (dram_addr == $past(addr)));

    assert_seg_off_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_area && shadow_seg_cfg == 8'h00) |=> !route_dram);

    assert_mode_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smm_ctl_cfg[5:4] == 2'b00) |=> !smram_hit);

    assert_reloc_offset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (smm_ctl_cfg[5:4] == 2'b11 && in_smm && reloc_win)
        |=> route_dram && smram_hit && (dram_addr[14:0] == $past(addr[14:0])));

    assert_closed_win_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_smm && !smm_ctl_cfg[3] && smm_ctl_cfg[5:4] == 2'b11 && reloc_win)
        |=> !route_dram && (dram_addr == $past(addr)));

    assert_bios_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_ctl_cfg[3:0] == 4'h0) |=> !bios_shadow_rd && !bios_shadow_wr);

endmodule

bind shsm_decoder shsm_decoder_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .addr           (addr),
    .acc_kind       (acc_kind),
    .in_smm         (in_smm),
    .shadow_seg_cfg (shadow_seg_cfg),
    .shadow_ctl_cfg (shadow_ctl_cfg),
    .smm_ctl_cfg    (smm_ctl_cfg),
    .smi_stat_cfg   (smi_stat_cfg),
    .route_dram     (route_dram),
    .dram_addr      (dram_addr),
    .smram_hit      (smram_hit),
    .bios_shadow_rd (bios_shadow_rd),
    .bios_shadow_wr (bios_shadow_wr)
);

// File: tb/shsm_decoder_tb.sv
module shsm_decoder_tb_top;
    localparam int ADDR_W = 24;
    localparam int NV     = 22;
    localparam int VW     = 8 + ADDR_W + 2 + 1 + 32 + 1 + ADDR_W + 1 + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [1:0]        acc_kind = 2'd0;
    logic              in_smm = 1'b0;
    logic [7:0]        seg = 8'h00, ctl = 8'h00, sctl = 8'h00, stat = 8'h00;
    logic              route_dram, smram_hit, bios_shadow_rd, bios_shadow_wr;
    logic [ADDR_W-1:0] dram_addr;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    shsm_decoder #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .acc_kind(acc_kind), .in_smm(in_smm),
        .shadow_seg_cfg(seg), .shadow_ctl_cfg(ctl), .smm_ctl_cfg(sctl), .smi_stat_cfg(stat),
        .route_dram(route_dram), .dram_addr(dram_addr), .smram_hit(smram_hit),
        .bios_shadow_rd(bios_shadow_rd), .bios_shadow_wr(bios_shadow_wr));

    // fields: req, addr, kind, smm, seg, ctl, sctl, stat, exp dram, exp addr, exp hit, exp {brd,bwr}
    localparam logic [VW-1:0] VEC [NV] = '{
        {8'd3,  24'h012345, 2'd0, 1'b0, 32'h00_00_00_00, 1'b1, 24'h012345, 1'b0, 2'b00}, // R3
        {8'd3,  24'h100000, 2'd1, 1'b0, 32'h00_00_00_00, 1'b1, 24'h100000, 1'b0, 2'b00}, // R3
        {8'd7,  24'h0B8000, 2'd0, 1'b0, 32'h00_00_00_00, 1'b0, 24'h0B8000, 1'b0, 2'b00}, // R7
        {8'd4,  24'h0C4000, 2'd0, 1'b0, 32'h02_10_00_00, 1'b1, 24'h0C4000, 1'b0, 2'b00}, // R4
        {8'd4,  24'h0C0000, 2'd0, 1'b0, 32'h02_10_00_00, 1'b0, 24'h0C0000, 1'b0, 2'b00}, // R4
        {8'd6,  24'h0C4000, 2'd1, 1'b0, 32'h02_10_00_00, 1'b0, 24'h0C4000, 1'b0, 2'b00}, // R6
        {8'd6,  24'h0C4000, 2'd1, 1'b0, 32'h02_20_00_00, 1'b1, 24'h0C4000, 1'b0, 2'b00}, // R6
        {8'd6,  24'h0DC000, 2'd2, 1'b0, 32'h80_10_00_00, 1'b1, 24'h0DC000, 1'b0, 2'b00}, // R6
        {8'd5,  24'h0F8000, 2'd0, 1'b0, 32'h00_18_00_00, 1'b1, 24'h0F8000, 1'b0, 2'b10}, // R5
        {8'd5,  24'h0F0000, 2'd0, 1'b0, 32'h00_18_00_00, 1'b0, 24'h0F0000, 1'b0, 2'b10}, // R5
        {8'd8,  24'h0A1000, 2'd0, 1'b1, 32'h00_00_10_00, 1'b1, 24'h0A1000, 1'b1, 2'b00}, // R8
        {8'd11, 24'h0A1000, 2'd0, 1'b0, 32'h00_00_10_00, 1'b0, 24'h0A1000, 1'b1, 2'b00}, // R11
        {8'd11, 24'h0A1000, 2'd1, 1'b0, 32'h00_00_18_00, 1'b1, 24'h0A1000, 1'b1, 2'b00}, // R11
        {8'd10, 24'h0A8010, 2'd0, 1'b1, 32'h00_00_30_80, 1'b1, 24'h068010, 1'b1, 2'b00}, // R10
        {8'd10, 24'h0A8010, 2'd0, 1'b1, 32'h00_00_30_40, 1'b1, 24'h038010, 1'b1, 2'b00}, // R10
        {8'd10, 24'h0A0010, 2'd0, 1'b1, 32'h00_00_30_80, 1'b0, 24'h0A0010, 1'b0, 2'b00}, // R10
        {8'd9,  24'h0E4000, 2'd0, 1'b1, 32'h00_00_20_00, 1'b1, 24'h0E4000, 1'b1, 2'b00}, // R9
        {8'd9,  24'h0E4000, 2'd0, 1'b1, 32'h00_21_20_00, 1'b0, 24'h0E4000, 1'b0, 2'b01}, // R9
        {8'd12, 24'h0B0000, 2'd2, 1'b0, 32'h00_00_11_00, 1'b1, 24'h0B0000, 1'b1, 2'b00}, // R12
        {8'd12, 24'h0B0000, 2'd0, 1'b0, 32'h00_00_11_00, 1'b0, 24'h0B0000, 1'b1, 2'b00}, // R12
        {8'd8,  24'h0A1000, 2'd0, 1'b1, 32'h00_00_08_00, 1'b0, 24'h0A1000, 1'b0, 2'b00}, // R8
        {8'd13, 24'h09FFFF, 2'd1, 1'b1, 32'h00_34_10_00, 1'b1, 24'h09FFFF, 1'b0, 2'b11}  // R13
    };

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        // R1: reset values with busy inputs applied
        addr = 24'h012345; ctl = 8'h3F; sctl = 8'h10; in_smm = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "route_dram", 32'(route_dram), 0);
        chk("R1", "dram_addr", 32'(dram_addr), 0);
        chk("R1", "smram_hit", 32'(smram_hit), 0);
        chk("R1", "bios_flags", 32'({bios_shadow_rd, bios_shadow_wr}), 0);

        // R2: one-cycle latency, stable between edges
        @(negedge clk);
        rst_n = 1'b1; addr = 24'h0B8000; ctl = 8'h00; sctl = 8'h00; in_smm = 1'b0;
        @(posedge clk); #2;
        chk("R2", "route_dram after edge", 32'(route_dram), 0);
        addr = 24'h012345;
        #1;
        chk("R2", "route_dram between edges", 32'(route_dram), 0);
        chk("R2", "dram_addr between edges", 32'(dram_addr), 32'h0B8000);
        @(posedge clk); #2;
        chk("R2", "route_dram next edge", 32'(route_dram), 1);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            string         rq;
            v = VEC[i];
            @(negedge clk);
            {addr, acc_kind, in_smm, seg, ctl, sctl, stat} = v[VW-9 -: ADDR_W+2+1+32];
            @(posedge clk); #2;
            rq = $sformatf("R%0d", v[VW-1 -: 8]);
            chk(rq, $sformatf("row %0d route_dram", i), 32'(route_dram), 32'(v[ADDR_W+3]));
            chk(rq, $sformatf("row %0d dram_addr", i), 32'(dram_addr), 32'(v[ADDR_W+2:3]));
            chk(rq, $sformatf("row %0d smram_hit", i), 32'(smram_hit), 32'(v[2]));
            chk(rq, $sformatf("row %0d bios_flags", i),
                32'({bios_shadow_rd, bios_shadow_wr}), 32'(v[1:0]));
        end

        // R1: reasserting reset clears the outputs again
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #2;
        chk("R1", "route_dram re-reset", 32'(route_dram), 0);
        chk("R1", "bios_flags re-reset", 32'({bios_shadow_rd, bios_shadow_wr}), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule